// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the address stream for a pipelined burst memory. It keeps a base address register. The two lowest address bits do not come from that register. A two-bit beat counter and a start value, captured together with the base, produce them instead. A new access begins when either of two active-low strobes is seen on a rising clock edge. One strobe is intended for a processor and one for a cache or memory controller. After the access begins, an active-low advance input steps through four beats and then wraps back to the first.

An ordering input chooses how the beats are laid out. In linear order the beat count is added to the start value modulo four. In interleaved order the start value is XORed with the beat count. The block also samples three chip enables when a new access begins: one primary active-low enable, one active-high enable and one active-low enable. From these it forms a registered select flag. The processor strobe is blocked while the primary enable is inactive. The controller strobe is never blocked, so it can load an access that leaves the device deselected. All pins are plain control and address lines. There is no streamed data interface, so no valid/ready handshake is involved.

Top module: `burst_addr_seq`

## Requirements
- R1: After a synchronous reset (`rst` high on a clock edge), `sel` and `first_beat` are 0 and `cur_addr` is 0.
- R2: When `proc_stb_n` is 0 and `en_pri_n` is 0 on a clock edge, `cur_addr` equals `addr_in` after that edge and `first_beat` is 1.
- R3: When `proc_stb_n` is 0 with `en_pri_n` 1 and `ctrl_stb_n` 1, the strobe is ignored: the upper address bits, the start value and `sel` keep their values.
- R4: When `ctrl_stb_n` is 0 on an edge, a new access is loaded whatever `en_pri_n` is. `sel` becomes 1 only if `en_pri_n`=0, `en_sec_hi`=1 and `en_sec_n`=0; otherwise it becomes 0.
- R5: The chip enables are sampled only when an access is loaded. On any other edge, `sel` keeps its value.
- R6: On an edge without a load, `adv_n`=0 moves to the next beat and clears `first_beat`. `adv_n`=1 holds `cur_addr` unchanged.
- R7: With `order_sel`=0 (linear), `cur_addr[1:0]` is (start + beat) mod 4.
- R8: With `order_sel`=1 (interleaved), `cur_addr[1:0]` is start XOR beat. For a start of 01, the beats are 01, 00, 11, 10.
- R9: After four advances, `cur_addr[1:0]` is back to its start value.
- R10: A strobe that arrives in the middle of a burst abandons that burst. The next beat is the new base address, with `first_beat`=1.
- R11: If both strobes are 0 while `en_pri_n` is 1, the controller strobe loads the access and `sel` becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_in | input | ADDR_W | External address, captured on a load |
| proc_stb_n | input | 1 | Processor address strobe, active low, blocked by `en_pri_n` |
| ctrl_stb_n | input | 1 | Controller address strobe, active low, never blocked |
| adv_n | input | 1 | Advance to next beat, active low |
| order_sel | input | 1 | 0 = linear order, 1 = interleaved order |
| en_pri_n | input | 1 | Primary chip enable, active low |
| en_sec_hi | input | 1 | Secondary chip enable, active high |
| en_sec_n | input | 1 | Secondary chip enable, active low |
| cur_addr | output | ADDR_W | Current burst address |
| sel | output | 1 | Registered device-select flag |
| first_beat | output | 1 | High on the first beat of a burst |

## Verification
The embedded assertions check several rules on every cycle:
- a load always restarts the beat count and raises the first-beat flag;
- a held advance freezes the counter;
- the select flag never changes without a load;
- a blocked processor strobe leaves the upper address alone;
- a linear advance adds exactly one to the low bits.

Other behaviour only shows up in the bench's scenarios, which compare the outputs against a behavioural model on every clock:
- the interleaved sequence values;
- the wrap after four beats;
- the restart in the middle of a burst;
- the priority between the two strobes;
- deselection by the controller strobe.

// File: rtl/bas_pkg.sv
package bas_pkg;
  localparam int BEAT_W = 2;
  typedef enum logic {ORD_LINEAR = 1'b0, ORD_XOR = 1'b1} order_e;
endpackage

// File: rtl/bas_strobe_arb.sv
module bas_strobe_arb (
  input  logic proc_stb_n,
  input  logic ctrl_stb_n,
  input  logic en_pri_n,
  input  logic en_sec_hi,
  input  logic en_sec_n,
  output logic load,
  output logic sel_next
);
  logic proc_go;
  logic ctrl_go;

  // processor strobe wins when it is allowed; controller strobe is never gated
  always_comb begin
    proc_go  = !proc_stb_n && !en_pri_n;
    ctrl_go  = !ctrl_stb_n && !proc_go;
    load     = proc_go || ctrl_go;
    sel_next = !en_pri_n && en_sec_hi && !en_sec_n;
  end
endmodule

// File: rtl/bas_beat_ctr.sv
module bas_beat_ctr #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [BEAT_W-1:0] start_in,
  input  logic              adv_n,
  output logic [BEAT_W-1:0] start_q,
  output logic [BEAT_W-1:0] beat_q,
  output logic              first_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      beat_q  <= '0;
      first_q <= 1'b0;
    end else if (load) begin
      start_q <= start_in;
      beat_q  <= '0;
      first_q <= 1'b1;
    end else begin
      if (!adv_n) beat_q <= beat_q + BEAT_W'(1);
      first_q <= 1'b0;
    end
  end

  assert_load_restarts_R2: assert property (@(posedge clk) disable iff (rst)
    load |=> (beat_q == '0) && first_q);

  assert_hold_on_no_adv_R6: assert property (@(posedge clk) disable iff (rst)
    (!load && adv_n) |=> $stable(beat_q) && $stable(start_q));
endmodule

// File: rtl/bas_addr_mix.sv
module bas_addr_mix
  import bas_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] start,
  input  logic [BEAT_W-1:0] beat,
  input  order_e            order,
  output logic [BEAT_W-1:0] low
);
  logic [BEAT_W-1:0] lin_low;
  logic [BEAT_W-1:0] xor_low;

  assign lin_low = start + beat;

  for (genvar b = 0; b < BEAT_W; b++) begin : g_xor
    assign xor_low[b] = start[b] ^ beat[b];
  end

  assign low = (order == ORD_XOR) ? xor_low : lin_low;
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bas_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              proc_stb_n,
  input  logic              ctrl_stb_n,
  input  logic              adv_n,
  input  logic              order_sel,
  input  logic              en_pri_n,
  input  logic              en_sec_hi,
  input  logic              en_sec_n,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              sel,
  output logic              first_beat
);
  localparam int HI_W = ADDR_W - BEAT_W;

  logic              load;
  logic              sel_next;
  logic [HI_W-1:0]   base_hi;
  logic [BEAT_W-1:0] start_q;
  logic [BEAT_W-1:0] beat_q;
  logic [BEAT_W-1:0] low_bits;

  bas_strobe_arb u_arb (
    .proc_stb_n (proc_stb_n),
    .ctrl_stb_n (ctrl_stb_n),
    .en_pri_n   (en_pri_n),
    .en_sec_hi  (en_sec_hi),
    .en_sec_n   (en_sec_n),
    .load       (load),
    .sel_next   (sel_next)
  );

  bas_beat_ctr #(.BEAT_W(BEAT_W)) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .start_in (addr_in[BEAT_W-1:0]),
    .adv_n    (adv_n),
    .start_q  (start_q),
    .beat_q   (beat_q),
    .first_q  (first_beat)
  );

  bas_addr_mix #(.BEAT_W(BEAT_W)) u_mix (
    .start (start_q),
    .beat  (beat_q),
    .order (order_e'(order_sel)),
    .low   (low_bits)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      base_hi <= '0;
      sel     <= 1'b0;
    end else if (load) begin
      base_hi <= addr_in[ADDR_W-1:BEAT_W];
      sel     <= sel_next;
    end
  end

  assign cur_addr = {base_hi, low_bits};

  assert_sel_only_on_load_R5: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(sel));

  assert_blocked_proc_ignored_R3: assert property (@(posedge clk) disable iff (rst)
    (!proc_stb_n && en_pri_n && ctrl_stb_n) |=> $stable(cur_addr[ADDR_W-1:BEAT_W]) && $stable(sel));

  assert_linear_step_R7: assert property (@(posedge clk) disable iff (rst)
    (!load && !adv_n && !order_sel) ##1 !order_sel |->
      cur_addr[BEAT_W-1:0] == BEAT_W'($past(cur_addr[BEAT_W-1:0]) + 1));

  assert_first_implies_load_R10: assert property (@(posedge clk) disable iff (rst)
    first_beat |-> $past(load));
endmodule

// File: tb/burst_addr_seq_bench.sv
`timescale 1ns/1ps
module burst_addr_seq_bench;
  localparam int AW = 17;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr_in = '0;
  logic          proc_stb_n = 1'b1, ctrl_stb_n = 1'b1, adv_n = 1'b1;
  logic          order_sel = 1'b0, en_pri_n = 1'b1, en_sec_hi = 1'b0, en_sec_n = 1'b1;
  logic [AW-1:0] cur_addr;
  logic          sel, first_beat;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // behavioural reference state
  int m_base = 0, m_start = 0, m_beat = 0;
  bit m_sel = 0, m_first = 0;

  always #2 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW)) u_burst_addr_seq (
    .clk(clk), .rst(rst), .addr_in(addr_in), .proc_stb_n(proc_stb_n),
    .ctrl_stb_n(ctrl_stb_n), .adv_n(adv_n), .order_sel(order_sel),
    .en_pri_n(en_pri_n), .en_sec_hi(en_sec_hi), .en_sec_n(en_sec_n),
    .cur_addr(cur_addr), .sel(sel), .first_beat(first_beat)
  );

  function automatic int exp_addr();
    int lo;
    lo = order_sel ? (m_start ^ m_beat) : ((m_start + m_beat) % 4);
    return ((m_base >> 2) << 2) | lo;
  endfunction

  task automatic compare(input string tag);
    int e;
    e = exp_addr();
    n_chk++;
    if (cur_addr !== AW'(e) || sel !== m_sel || first_beat !== m_first) begin
      n_bad++;
      $display("FAIL %s: addr=%0h sel=%0b first=%0b expected addr=%0h sel=%0b first=%0b",
               tag, cur_addr, sel, first_beat, e, m_sel, m_first);
    end
  endtask

  // apply inputs now (at negedge), advance model across one edge, compare
  task automatic step(input string tag, input int a, input bit ps, input bit cs,
                      input bit av, input bit ord, input bit ep, input bit eh, input bit en);
    bit pgo, load;
    addr_in = AW'(a); proc_stb_n = ps; ctrl_stb_n = cs; adv_n = av;
    order_sel = ord; en_pri_n = ep; en_sec_hi = eh; en_sec_n = en;
    pgo  = !ps && !ep;
    load = pgo || !cs;
    @(posedge clk);
    if (rst) begin
      m_base = 0; m_start = 0; m_beat = 0; m_sel = 0; m_first = 0;
    end else if (load) begin
      m_base = a; m_start = a % 4; m_beat = 0; m_first = 1;
      m_sel = !ep && eh && !en;
    end else begin
      if (!av) m_beat = (m_beat + 1) % 4;
      m_first = 0;
    end
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #(4 * 5000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    step("R1 reset", 'h1abcd, 0, 0, 0, 0, 0, 1, 0);
    step("R1 reset hold", 'h0, 1, 1, 1, 0, 1, 0, 1);
    rst = 1'b0;
    step("R1 idle after reset", 'h0, 1, 1, 1, 0, 1, 0, 1);
    // R2 processor load, linear order, start 01, R7 + R9 wrap
    step("R2 proc load", 'h12345, 0, 1, 1, 0, 0, 1, 0);
    for (int i = 0; i < 4; i++) step("R7 R9 linear advance", 'h0, 1, 1, 0, 0, 1, 0, 1);
    // R6 hold with advance deasserted
    step("R6 hold", 'h0, 1, 1, 1, 0, 1, 0, 1);
    step("R6 hold again", 'h0, 1, 1, 1, 0, 1, 0, 1);
    // R8 interleaved, start 01 -> 01 00 11 10
    step("R8 proc load xor", 'h00a01, 0, 1, 1, 1, 0, 1, 0);
    for (int i = 0; i < 4; i++) step("R8 R9 xor advance", 'h0, 1, 1, 0, 1, 1, 0, 1);
    // R3 blocked processor strobe, with advancing and without
    step("R3 blocked strobe", 'h1fff2, 0, 1, 1, 1, 1, 1, 0);
    step("R3 blocked strobe adv", 'h1fff3, 0, 1, 0, 1, 1, 0, 0);
    // R5 secondary enables toggle without load
    step("R5 enables no load", 'h0, 1, 1, 1, 1, 0, 0, 1);
    // R4 controller load selecting, then deselecting
    step("R4 ctrl load select", 'h0fe06, 1, 0, 1, 0, 0, 1, 0);
    step("R4 ctrl advance", 'h0, 1, 1, 0, 0, 1, 0, 1);
    step("R4 ctrl deselect", 'h03333, 1, 0, 1, 0, 0, 0, 0);
    step("R4 ctrl deselect pri", 'h04444, 1, 0, 1, 0, 1, 1, 0);
    // R11 both strobes with primary enable inactive
    step("R2 proc reselect", 'h05555, 0, 1, 1, 0, 0, 1, 0);
    step("R11 both strobes blocked", 'h06667, 0, 0, 1, 0, 1, 1, 0);
    step("R11 both strobes allowed", 'h07778, 0, 0, 1, 0, 0, 1, 0);
    // R10 restart mid burst
    step("R10 adv", 'h0, 1, 1, 0, 0, 1, 0, 1);
    step("R10 adv", 'h0, 1, 1, 0, 1, 1, 0, 1);
    step("R10 restart", 'h1a0b3, 0, 1, 0, 1, 0, 1, 0);
    for (int i = 0; i < 3; i++) step("R10 continue", 'h0, 1, 1, 0, 1, 1, 0, 1);
    // mixed pattern sweep
    for (int k = 0; k < 16; k++) begin
      step("R7 R8 sweep load", k * 4099 + k, 0, 1, 1, k[0], 0, 1, 0);
      for (int j = 0; j < 5; j++) step("R6 R9 sweep adv", 'h0, 1, 1, j[1], k[1], 1, 0, 1);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule